// File: doc/BRIEF.md
# Three-Tap Shift-Add FIR Filter with Shared Partial Term

This block is a three-tap fixed-point FIR filter built in transposed form. It has no multipliers. Each coefficient is an 8-bit unsigned binary fraction, and each is realised as a sum of arithmetic right shifts of the input sample. The sum x + x/8 + x/64 is formed once per sample. Halved, it supplies most of the weight of both the middle tap and the last tap, and a single extra shifted copy of the input finishes each of those two taps. The first tap is a plain sum of four shifted copies of the input.

The coefficients are 43/256 for the current sample, 154/256 for the previous sample and 210/256 for the sample before that. The computed products feed a chain of two adder-and-register stages, as the transposed structure requires.

A sample is accepted on every clock where the input valid is high, and nothing changes on other clocks. The filtered result for an accepted sample appears one clock later, together with an output valid pulse. By default the output carries the full internal word, with 8 fractional bits, so no precision is lost. A parameter can instead select an output that keeps only the integer part, truncated toward minus infinity.

Top module: `fir3_shared_tr`

## Requirements
- R1: While the synchronous reset `rst` is high, every clock edge clears the output, the output valid and both internal partial sums to zero. The first output after reset therefore depends only on the first accepted sample.
- R2: For an accepted sample x(n), the output on the following clock equals 43·x(n) + 154·x(n−1) + 210·x(n−2). The value is expressed in units of 2^-8, so the output LSB weighs 2^-8 of an input LSB. Here x(n−k) is the k-th earlier accepted sample since reset, and is zero if no such sample exists.
- R3: A single accepted sample of value v, followed by accepted zeros, gives the outputs 43v, 154v, 210v and then 0.
- R4: At full precision the output is DW+10 bits wide and signed. Neither the largest positive nor the most negative input stream overflows or wraps the output.
- R5: On a clock where `in_vld` is low, the output and the internal sums keep their values. Later accepted samples continue the filter as if the idle clocks had not occurred.
- R6: `out_vld` is high exactly on the clocks that follow a clock where `in_vld` was high, outside reset.
- R7: With DROP_FRAC=1 the output is DW+2 bits wide. It equals floor((43·x(n) + 154·x(n−1) + 210·x(n−2)) / 256).
- R8: A reset asserted in the middle of a sample stream discards all earlier samples from later outputs.
- R9: After three accepted zero samples in a row, the output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Sample valid; the state advances only when high |
| x | input | DW | Signed input sample |
| out_vld | output | 1 | High one clock after an accepted sample |
| y | output | DW+10, or DW+2 if DROP_FRAC=1 | Signed filtered output |

## Verification
Impulses of both signs isolate each coefficient in turn. They show whether the shared term is halved correctly and whether the right extra shift is added for each tap. Dense random samples exercise all three taps together. Random samples with random idle gaps separate a correct stall from one that shifts the history. A run of extreme values at both ends of the range, a zero flush, and a reset in the middle of a stream cover overflow, clearing of state and discarding of history. A second instance with the truncated output is compared against the floor of the same reference on every clock.

// File: rtl/fir3_shared_tr.sv
module fir3_shared_tr #(
  parameter int DW        = 12,
  parameter bit DROP_FRAC = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] x,
  output logic                 out_vld,
  output logic signed [(DROP_FRAC ? DW+2 : DW+10)-1:0] y
);
  localparam int FRAC = 8;
  localparam int AW   = DW + FRAC + 2;
  localparam int YW   = DROP_FRAC ? AW - FRAC : AW;

  logic signed [AW-1:0] xe, x2, tap0, tap1, tap2;
  logic signed [AW-1:0] r1, r2, acc_q;

  // input widened with 8 fractional bits so every right shift is exact
  assign xe   = {{2{x[DW-1]}}, x, {FRAC{1'b0}}};
  // shared term, formed once per sample
  assign x2   = xe + (xe >>> 3) + (xe >>> 6);
  assign tap0 = (xe >>> 3) + (xe >>> 5) + (xe >>> 7) + (xe >>> 8);
  assign tap1 = (x2 >>> 1) + (xe >>> 5);
  assign tap2 = (x2 >>> 1) + (xe >>> 2);

  always_ff @(posedge clk) begin
    if (rst) begin
      r1      <= '0;
      r2      <= '0;
      acc_q   <= '0;
      out_vld <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) begin
        r2    <= tap2;
        r1    <= tap1 + r2;
        acc_q <= tap0 + r1;
      end
    end
  end

  assign y = acc_q[AW-1 -: YW];

  // ---------------- assertions ----------------
  logic       rst_q;
  logic [1:0] zrun;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst)                zrun <= 2'd0;
    else if (in_vld)        zrun <= (x != '0) ? 2'd0 : ((zrun == 2'd3) ? 2'd3 : zrun + 2'd1);
  end

  always_comb begin
    if (rst_q) p_reset_clear_r1: assert (acc_q == '0 && r1 == '0 && r2 == '0 && !out_vld);
  end

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(acc_q) && $stable(r1) && $stable(r2) && !out_vld));

  p_valid_follow_r6: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld);

  p_zero_flush_r9: assert property (@(posedge clk) disable iff (rst)
    (zrun == 2'd3) |-> (acc_q == '0));

endmodule

// File: tb/test_fir3_shared_tr.sv
`timescale 1ns/1ps
module test_fir3_shared_tr;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic signed [DW-1:0] x = '0;
  logic out_vld, out_vld_t;
  logic signed [DW+9:0] y;
  logic signed [DW+1:0] y_t;

  always #2 clk = ~clk;

  fir3_shared_tr #(.DW(DW), .DROP_FRAC(1'b0)) i_fir3_shared_tr (
    .clk(clk), .rst(rst), .in_vld(in_vld), .x(x), .out_vld(out_vld), .y(y));
  fir3_shared_tr #(.DW(DW), .DROP_FRAC(1'b1)) i_fir3_shared_tr_trunc (
    .clk(clk), .rst(rst), .in_vld(in_vld), .x(x), .out_vld(out_vld_t), .y(y_t));

  int tests = 0, fails = 0, cycles = 0;
  longint m_y = 0, h1 = 0, h2 = 0;
  bit m_v = 1'b0;
  string prev_req = "R1";

  // behavioural reference: remembers the last two accepted samples
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_y <= 0; m_v <= 1'b0; h1 <= 0; h2 <= 0;
    end else if (in_vld) begin
      m_y <= 43 * longint'(x) + 154 * h1 + 210 * h2;
      h2 <= h1; h1 <= longint'(x); m_v <= 1'b1;
    end else begin
      m_v <= 1'b0;
    end
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected <150000", cycles);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic compare(input string req);
    longint et;
    et = m_y >>> 8;
    tests++;
    if (longint'(y) != m_y || out_vld != m_v) begin
      fails++;
      $display("FAIL %s: y=%0d vld=%0b expected y=%0d vld=%0b", req, y, out_vld, m_y, m_v);
    end
    tests++;
    if (longint'(y_t) != et || out_vld_t != m_v) begin
      fails++;
      $display("FAIL R7 (%s): y=%0d vld=%0b expected y=%0d vld=%0b", req, y_t, out_vld_t, et, m_v);
    end
  endtask

  task automatic step(input bit r, input bit v, input int xv, input string req);
    @(negedge clk);
    compare(prev_req);
    rst = r; in_vld = v; x = xv[DW-1:0];
    prev_req = req;
  endtask

  function automatic int rnd_x();
    return int'($urandom_range(4095)) - 2048;
  endfunction

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 0, "R1");
    step(1'b0, 1'b1, 7, "R1");
    // R3: impulses of both signs
    step(1'b0, 1'b1, 1, "R3");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 0, "R3");
    step(1'b0, 1'b1, -5, "R3");
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 0, "R3");
    // R2: dense random samples
    for (int i = 0; i < 800; i++) step(1'b0, 1'b1, rnd_x(), "R2");
    // R5 / R6: random idle gaps
    for (int i = 0; i < 800; i++) step(1'b0, ($urandom_range(2) != 0), rnd_x(), "R5");
    for (int i = 0; i < 200; i++) step(1'b0, i[0], rnd_x(), "R6");
    // R4: extremes at both ends
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 2047, "R4");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, -2048, "R4");
    for (int i = 0; i < 20; i++) step(1'b0, 1'b1, i[0] ? 2047 : -2048, "R4");
    // R9: zero flush after noise
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, rnd_x(), "R9");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 0, "R9");
    // R8: reset in the middle of a stream
    for (int i = 0; i < 10; i++) step(1'b0, 1'b1, rnd_x(), "R8");
    step(1'b1, 1'b1, 1234, "R8");
    step(1'b0, 1'b1, 100, "R8");
    step(1'b0, 1'b1, 0, "R8");
    step(1'b0, 1'b1, 0, "R8");
    step(1'b0, 1'b0, 0, "R8");
    @(negedge clk);
    compare(prev_req);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule